// File: doc/BRIEF.md
# Dual-Tag Synonym-Resolving Cache Controller

This block holds the tags, line state and a small data array for a virtually indexed, direct-mapped cache. It keeps two tag stores. The virtual store is indexed by the low bits of the virtual line address. The physical store is indexed by the low bits of the physical line address. Every resident line owns one entry in each store, and each entry holds the other's index. Because of these cross pointers, two virtual addresses that alias one physical line are found and merged in hardware, with no help from page colouring. A bus snoop needs only the physical address: it goes through the physical store, and the pointer stored there leads to the line's state and data.

The processor side presents a virtual and physical line address pair, with an optional write. The block answers with a hit, a miss or a synonym relocation. A miss raises a fill request, and the fill data is taken in while that request is high. A snoop is a single-cycle probe. Its answer one cycle later gives hit, state, virtual index and line data. A snoop is always served first, and the processor side stands still in any cycle that has a snoop in it.

Top module: `dt_synonym_cache`

## Requirements
- R1: An access whose virtual index entry holds a matching virtual tag answers with kind HIT and the line data. A write also stores the write data and moves the line to M.
- R2: If the virtual tag misses but the physical tag matches, the answer is kind SYN. The line's data and state move to the current virtual index, the old virtual entry is cleared, and the old virtual address no longer hits.
- R3: After a relocation, the physical entry points to the new virtual index, and a snoop reports that index.
- R4: If both tags miss, fill_req is high with fill_pa equal to the request's physical address in the cycle before the kind MISS answer. The line is then installed with fill_data (or with the write data for a write), in state E for a read or M for a write.
- R5: Installing or relocating into a virtual index first removes the line already there, from both stores, so snoops to that line miss.
- R6: Installing a line whose physical index already holds another line removes that other line from both stores.
- R7: A snoop presented in one cycle is answered in the next with hit, state, virtual index and data. A snoop miss reports hit 0, state I, index 0 and data 0.
- R8: Each line has a single state, coded I=0, S=1, E=2, M=3. A snoop reports the state set by processor accesses, and that state is carried through a relocation.
- R9: While snp_valid is high, no request is accepted and the processor-side sequence does not advance.
- R10: After reset the block is busy while it clears every tag entry. After that, every lookup misses.
- R11: After every answer, the virtual entry at the request's index and the physical entry at its physical index are valid and point at each other.
- R12: resp_kind is coded HIT=0, MISS=1, SYN=2, and resp_valid is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when busy and snp_valid are low |
| req_write | input | 1 | Request is a write |
| req_va | input | VA_W | Virtual line address |
| req_pa | input | PA_W | Physical line address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Processor side occupied |
| resp_valid | output | 1 | Answer pulse |
| resp_kind | output | 2 | HIT=0, MISS=1, SYN=2 |
| resp_rdata | output | DATA_W | Line data after the access |
| fill_req | output | 1 | Fill wanted for fill_pa |
| fill_pa | output | PA_W | Physical line address to fill |
| fill_data | input | DATA_W | Fill data, taken while fill_req is high |
| snp_valid | input | 1 | Snoop probe |
| snp_pa | input | PA_W | Snoop physical line address |
| snp_resp_valid | output | 1 | Snoop answer pulse |
| snp_hit | output | 1 | Snoop found the line |
| snp_state | output | 2 | Line state |
| snp_vidx | output | VIDX_W | Virtual index holding the line |
| snp_data | output | DATA_W | Line data |

## Verification
The bench targets aliases that land on a different virtual index, aliases that share an index and differ only in virtual tag, and relocations into an index held by an unrelated line. A design with a stale physical pointer would return the wrong index from a snoop. A design that skipped the victim clean-up would leave a phantom line that still answers snoops. Physical-index collisions on a miss are also exercised: leaving the displaced line's virtual entry in place would produce false hits. Snoops are placed in the middle of a relocation and in the same cycle as a new request, which exposes a sequence that advances under a snoop or answers with half-moved state.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;

  localparam logic [1:0] RK_HIT  = 2'd0;
  localparam logic [1:0] RK_MISS = 2'd1;
  localparam logic [1:0] RK_SYN  = 2'd2;

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_LOOK, S_MEVICT, S_MFILL, S_SRD, S_SWR, S_STAG
  } ctl_state_e;
endpackage

// File: rtl/dt_regfile.sv
// One write port, two asynchronous read ports; no reset so it maps to LUT RAM.
module dt_regfile #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dt_snoop_stage.sv
// Registers the snoop answer; misses are forced to all-zero fields.
module dt_snoop_stage
  import dt_pkg::*;
#(
  parameter int VIDX_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_hit,
  input  logic [1:0]        in_state,
  input  logic [VIDX_W-1:0] in_vidx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_hit,
  output logic [1:0]        out_state,
  output logic [VIDX_W-1:0] out_vidx,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_state <= ST_I;
      out_vidx  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid && in_hit;
      out_state <= (in_valid && in_hit) ? in_state : ST_I;
      out_vidx  <= (in_valid && in_hit) ? in_vidx : '0;
      out_data  <= (in_valid && in_hit) ? in_data : '0;
    end
  end

  AST_SNOOP_ANSWERS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7
  AST_SNOOP_HIT_STATE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_hit) |-> (out_state != ST_I)); // R8
endmodule

// File: rtl/dt_synonym_cache.sv
module dt_synonym_cache
  import dt_pkg::*;
#(
  parameter int VA_W   = 8,
  parameter int PA_W   = 8,
  parameter int VIDX_W = 3,
  parameter int PIDX_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PA_W-1:0]   req_pa,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              resp_valid,
  output logic [1:0]        resp_kind,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              fill_req,
  output logic [PA_W-1:0]   fill_pa,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [PA_W-1:0]   snp_pa,
  output logic              snp_resp_valid,
  output logic              snp_hit,
  output logic [1:0]        snp_state,
  output logic [VIDX_W-1:0] snp_vidx,
  output logic [DATA_W-1:0] snp_data
);
  localparam int VTAG_W = VA_W - VIDX_W;
  localparam int PTAG_W = PA_W - PIDX_W;
  localparam int VE_W   = 1 + VTAG_W + PIDX_W + 2;   // valid, vtag, pptr, state
  localparam int PE_W   = 1 + PTAG_W + VIDX_W;       // valid, ptag, vptr
  localparam int SW_W   = (VIDX_W > PIDX_W) ? VIDX_W : PIDX_W;
  localparam logic [SW_W-1:0] SW_LAST = '1;

  ctl_state_e fsm;
  logic [SW_W-1:0]   sweep;
  logic              rq_write;
  logic [VIDX_W-1:0] rq_vidx;
  logic [VTAG_W-1:0] rq_vtag;
  logic [PIDX_W-1:0] rq_pidx;
  logic [PTAG_W-1:0] rq_ptag;
  logic [PA_W-1:0]   rq_pa;
  logic [DATA_W-1:0] rq_wdata;
  logic              vic_valid;
  logic [PIDX_W-1:0] vic_pptr;
  logic              pc_valid;
  logic [VIDX_W-1:0] pc_vptr;
  logic [VIDX_W-1:0] old_vidx;
  logic [1:0]        mv_st;
  logic [DATA_W-1:0] mv_data;

  // Store ports
  logic              v_we, p_we, d_we;
  logic [VIDX_W-1:0] v_wa, d_wa, v_ra_a, v_ra_b;
  logic [PIDX_W-1:0] p_wa, p_ra_b;
  logic [VE_W-1:0]   v_wd, ve_a, ve_b;
  logic [PE_W-1:0]   p_wd, pe_a, pe_b;
  logic [DATA_W-1:0] d_wd, d_rd_a, d_rd_b;

  // Decoded fields
  logic              va_valid, pa_valid, pb_valid;
  logic [VTAG_W-1:0] va_vtag;
  logic [PIDX_W-1:0] va_pptr;
  logic [1:0]        va_st, vb_st;
  logic [PTAG_W-1:0] pa_ptag, pb_ptag;
  logic [VIDX_W-1:0] pa_vptr, pb_vptr;
  logic              vhit, phit, s_hit;

  assign va_valid = ve_a[VE_W-1];
  assign va_vtag  = ve_a[VE_W-2 -: VTAG_W];
  assign va_pptr  = ve_a[2 +: PIDX_W];
  assign va_st    = ve_a[1:0];
  assign vb_st    = ve_b[1:0];
  assign pa_valid = pe_a[PE_W-1];
  assign pa_ptag  = pe_a[PE_W-2 -: PTAG_W];
  assign pa_vptr  = pe_a[VIDX_W-1:0];
  assign pb_valid = pe_b[PE_W-1];
  assign pb_ptag  = pe_b[PE_W-2 -: PTAG_W];
  assign pb_vptr  = pe_b[VIDX_W-1:0];

  assign vhit   = va_valid && (va_vtag == rq_vtag);
  assign phit   = pa_valid && (pa_ptag == rq_ptag);
  assign v_ra_a = (fsm == S_SRD) ? old_vidx : rq_vidx;
  assign p_ra_b = snp_pa[PIDX_W-1:0];
  assign v_ra_b = pb_vptr;
  assign s_hit  = pb_valid && (pb_ptag == snp_pa[PA_W-1:PIDX_W]) && (fsm != S_INIT);

  dt_regfile #(.W(VE_W), .AW(VIDX_W)) u_vtags (
    .clk(clk), .we(v_we), .waddr(v_wa), .wdata(v_wd),
    .raddr_a(v_ra_a), .rdata_a(ve_a), .raddr_b(v_ra_b), .rdata_b(ve_b));

  dt_regfile #(.W(PE_W), .AW(PIDX_W)) u_ptags (
    .clk(clk), .we(p_we), .waddr(p_wa), .wdata(p_wd),
    .raddr_a(rq_pidx), .rdata_a(pe_a), .raddr_b(p_ra_b), .rdata_b(pe_b));

  dt_regfile #(.W(DATA_W), .AW(VIDX_W)) u_data (
    .clk(clk), .we(d_we), .waddr(d_wa), .wdata(d_wd),
    .raddr_a(v_ra_a), .rdata_a(d_rd_a), .raddr_b(v_ra_b), .rdata_b(d_rd_b));

  dt_snoop_stage #(.VIDX_W(VIDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst), .in_valid(snp_valid), .in_hit(s_hit),
    .in_state(vb_st), .in_vidx(pb_vptr), .in_data(d_rd_b),
    .out_valid(snp_resp_valid), .out_hit(snp_hit), .out_state(snp_state),
    .out_vidx(snp_vidx), .out_data(snp_data));

  // Store writes: at most one per store per cycle, none while a snoop is present.
  always_comb begin
    v_we = 1'b0; v_wa = rq_vidx; v_wd = '0;
    p_we = 1'b0; p_wa = rq_pidx; p_wd = '0;
    d_we = 1'b0; d_wa = rq_vidx; d_wd = rq_wdata;
    if (!snp_valid) begin
      unique case (fsm)
        S_INIT: begin
          v_we = 1'b1; v_wa = sweep[VIDX_W-1:0];
          p_we = 1'b1; p_wa = sweep[PIDX_W-1:0];
        end
        S_LOOK: begin
          if (vhit && rq_write) begin
            v_we = 1'b1; v_wd = {1'b1, rq_vtag, va_pptr, ST_M};
            d_we = 1'b1;
          end
        end
        S_MEVICT: begin
          if (vic_valid) begin p_we = 1'b1; p_wa = vic_pptr; end
          if (pc_valid)  begin v_we = 1'b1; v_wa = pc_vptr;  end
        end
        S_MFILL: begin
          v_we = 1'b1; v_wd = {1'b1, rq_vtag, rq_pidx, rq_write ? ST_M : ST_E};
          p_we = 1'b1; p_wd = {1'b1, rq_ptag, rq_vidx};
          d_we = 1'b1; d_wd = rq_write ? rq_wdata : fill_data;
        end
        S_SRD: begin
          if (vic_valid && (vic_pptr != rq_pidx)) begin
            p_we = 1'b1; p_wa = vic_pptr;
          end
        end
        S_SWR: begin
          v_we = 1'b1; v_wd = {1'b1, rq_vtag, rq_pidx, rq_write ? ST_M : mv_st};
          p_we = 1'b1; p_wd = {1'b1, rq_ptag, rq_vidx};
          d_we = 1'b1; d_wd = rq_write ? rq_wdata : mv_data;
        end
        S_STAG: begin
          if (old_vidx != rq_vidx) begin v_we = 1'b1; v_wa = old_vidx; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm <= S_INIT; sweep <= '0; busy <= 1'b1;
      resp_valid <= 1'b0; resp_kind <= RK_HIT; resp_rdata <= '0;
      fill_req <= 1'b0; fill_pa <= '0;
      rq_write <= 1'b0; rq_vidx <= '0; rq_vtag <= '0; rq_pidx <= '0;
      rq_ptag <= '0; rq_pa <= '0; rq_wdata <= '0;
      vic_valid <= 1'b0; vic_pptr <= '0; pc_valid <= 1'b0; pc_vptr <= '0;
      old_vidx <= '0; mv_st <= ST_I; mv_data <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (!snp_valid) begin
        unique case (fsm)
          S_INIT: begin
            sweep <= sweep + 1'b1;
            if (sweep == SW_LAST) begin fsm <= S_IDLE; busy <= 1'b0; end
          end
          S_IDLE: begin
            if (req_valid) begin
              rq_write <= req_write;
              rq_vidx  <= req_va[VIDX_W-1:0];
              rq_vtag  <= req_va[VA_W-1:VIDX_W];
              rq_pidx  <= req_pa[PIDX_W-1:0];
              rq_ptag  <= req_pa[PA_W-1:PIDX_W];
              rq_pa    <= req_pa;
              rq_wdata <= req_wdata;
              busy     <= 1'b1;
              fsm      <= S_LOOK;
            end
          end
          S_LOOK: begin
            vic_valid <= va_valid; vic_pptr <= va_pptr;
            pc_valid  <= pa_valid; pc_vptr  <= pa_vptr;
            if (vhit) begin
              resp_valid <= 1'b1; resp_kind <= RK_HIT;
              resp_rdata <= rq_write ? rq_wdata : d_rd_a;
              busy <= 1'b0; fsm <= S_IDLE;
            end else if (phit) begin
              old_vidx <= pa_vptr; fsm <= S_SRD;
            end else begin
              fsm <= S_MEVICT;
            end
          end
          S_MEVICT: begin
            fill_req <= 1'b1; fill_pa <= rq_pa; fsm <= S_MFILL;
          end
          S_MFILL: begin
            fill_req <= 1'b0;
            resp_valid <= 1'b1; resp_kind <= RK_MISS;
            resp_rdata <= rq_write ? rq_wdata : fill_data;
            busy <= 1'b0; fsm <= S_IDLE;
          end
          S_SRD: begin
            mv_st <= va_st; mv_data <= d_rd_a; fsm <= S_SWR;
          end
          S_SWR: fsm <= S_STAG;
          S_STAG: begin
            resp_valid <= 1'b1; resp_kind <= RK_SYN;
            resp_rdata <= rq_write ? rq_wdata : mv_data;
            busy <= 1'b0; fsm <= S_IDLE;
          end
          default: fsm <= S_IDLE;
        endcase
      end
    end
  end

  AST_SNOOP_HOLDS_FSM: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> (fsm == $past(fsm))); // R9
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (fsm == S_IDLE && req_valid && !snp_valid) |=> busy); // R9
  AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_kind == RK_MISS) |-> $past(fill_req)); // R4
  AST_PAIRED_POINTERS: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (va_valid && va_pptr == rq_pidx && pa_valid && pa_vptr == rq_vidx)); // R11
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R12
endmodule

// File: tb/tb_dt_synonym_cache.sv
module tb_dt_synonym_cache;
  localparam int CLK_PERIOD = 10;
  localparam int IMASK = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_va = 0, req_pa = 0, fill_pa, snp_pa = 0;
  logic [15:0] req_wdata = 0, resp_rdata, fill_data = 0, snp_data;
  logic busy, resp_valid, fill_req, snp_valid = 0, snp_resp_valid, snp_hit;
  logic [1:0] resp_kind, snp_state;
  logic [2:0] snp_vidx;

  int checks = 0, fails = 0;
  int res_va[int];
  int res_st[int];
  int mem[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  dt_synonym_cache dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_va(req_va), .req_pa(req_pa), .req_wdata(req_wdata), .busy(busy),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_rdata(resp_rdata),
    .fill_req(fill_req), .fill_pa(fill_pa), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_pa(snp_pa), .snp_resp_valid(snp_resp_valid),
    .snp_hit(snp_hit), .snp_state(snp_state), .snp_vidx(snp_vidx), .snp_data(snp_data));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int memval(int pa);
    return mem.exists(pa) ? mem[pa] : ((pa * 97 + 13) & 16'hFFFF);
  endfunction

  // Compare the snoop outputs (visible now) against the model for address pa.
  task automatic snp_now(int pa, string rq);
    bit eh = res_va.exists(pa);
    chk(snp_resp_valid === 1'b1, rq, "snoop answer present", snp_resp_valid, 1);
    chk(snp_hit === eh, rq, "snoop hit", snp_hit, eh);
    chk(snp_state === (eh ? res_st[pa] : 0), rq, "snoop state", snp_state, eh ? res_st[pa] : 0);
    chk(snp_vidx === (eh ? (res_va[pa] & IMASK) : 0), rq, "snoop vidx R11", snp_vidx,
        eh ? (res_va[pa] & IMASK) : 0);
    chk(snp_data === (eh ? memval(pa) : 0), rq, "snoop data", snp_data, eh ? memval(pa) : 0);
  endtask

  task automatic snoop(int pa, string rq);
    @(negedge clk);
    while (busy) @(negedge clk);
    snp_valid = 1; snp_pa = pa[7:0];
    @(negedge clk);
    snp_valid = 0;
    snp_now(pa, rq);
  endtask

  // mode 0: plain, 1: snoop mid-sequence, 2: snoop in the request's own cycle
  task automatic run(int va, int pa, bit wr, int wd, int mode);
    int ek, ed, fpa = -1;
    bit got = 0, fseen = 0;
    int kill[$];
    string rq;
    if (res_va.exists(pa) && res_va[pa] == va) ek = 0;
    else if (res_va.exists(pa)) ek = 2;
    else ek = 1;
    ed = wr ? wd : memval(pa);
    rq = (ek == 0) ? "R1" : (ek == 2) ? "R2" : "R4";
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_write = wr; req_va = va[7:0]; req_pa = pa[7:0];
    req_wdata = wd[15:0]; fill_data = memval(pa);
    if (mode == 2) begin snp_valid = 1; snp_pa = pa[7:0]; end
    @(negedge clk);
    if (mode == 2) begin
      chk(busy === 1'b0, "R9", "request held during snoop", busy, 0);
      snp_now(pa, "R9");
      snp_valid = 0;
      @(negedge clk);
      chk(busy === 1'b1, "R9", "request taken after snoop", busy, 1);
    end
    req_valid = 0;
    for (int n = 0; n < 40; n++) begin
      if (mode == 1 && n == 1) begin snp_valid = 0; snp_now(pa, "R7"); end
      if (mode == 1 && n == 0) begin snp_valid = 1; snp_pa = pa[7:0]; end
      @(negedge clk);
      if (fill_req) begin fseen = 1; fpa = fill_pa; end
      if (resp_valid) begin got = 1; break; end
    end
    chk(got, rq, "answer arrived", got, 1);
    chk(resp_kind === ek[1:0], rq, "kind R12", resp_kind, ek);
    chk(resp_rdata === ed[15:0], rq, "data", resp_rdata, ed);
    if (ek == 1) chk(fseen && fpa == pa, "R4", "fill request address", fpa, pa);
    @(negedge clk);
    chk(resp_valid === 1'b0, "R12", "answer is one pulse", resp_valid, 0);
    foreach (res_va[k])
      if (k != pa && (((res_va[k] & IMASK) == (va & IMASK)) || ((k & IMASK) == (pa & IMASK))))
        kill.push_back(k);
    foreach (kill[i]) begin res_va.delete(kill[i]); res_st.delete(kill[i]); end
    res_st[pa] = (ek == 1) ? (wr ? 3 : 2) : (wr ? 3 : res_st[pa]);
    res_va[pa] = va;
    if (wr) mem[pa] = wd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    int pool[6];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 1'b1, "R10", "busy while clearing", busy, 1);
    chk(resp_valid === 1'b0, "R10", "no answer after reset", resp_valid, 0);
    chk(fill_req === 1'b0, "R10", "no fill after reset", fill_req, 0);
    snoop(8'h21, "R10");
    run(8'h11, 8'h21, 0, 0, 0);
    run(8'h11, 8'h21, 0, 0, 0);
    run(8'h11, 8'h21, 1, 16'hBEEF, 0);
    snoop(8'h21, "R8");
    run(8'h46, 8'h21, 0, 0, 0);
    snoop(8'h21, "R3");
    run(8'h11, 8'h21, 0, 0, 1);
    snoop(8'h21, "R3");
    run(8'h91, 8'h21, 0, 0, 0);
    snoop(8'h21, "R2");
    run(8'h31, 8'h52, 0, 0, 0);
    snoop(8'h21, "R5");
    run(8'h13, 8'h62, 1, 16'h1234, 0);
    snoop(8'h52, "R6");
    run(8'h04, 8'h75, 0, 0, 0);
    run(8'h24, 8'h62, 0, 0, 0);
    snoop(8'h75, "R5");
    snoop(8'h62, "R8");
    run(8'h24, 8'h62, 0, 0, 2);
    run(8'h31, 8'h52, 0, 0, 0);
    for (int k = 0; k < 6; k++) pool[k] = (k * 41 + 3) & 8'hFF;
    for (int i = 0; i < 60; i++) begin
      int k = $urandom_range(0, 5);
      int va = ($urandom_range(0, 3) << 6) | (k << 3) | $urandom_range(0, 7);
      run(va, pool[k], 1'($urandom_range(0, 1)), $urandom_range(0, 16'hFFFF),
          (i % 7 == 3 && res_va.exists(pool[k])) ? 1 : 0);
      snoop(pool[$urandom_range(0, 5)], "R7");
    end
    summary();
  end
endmodule